// File: doc/BRIEF.md
# Opcode Fetch Bus Cycle Sequencer

This block runs the opcode fetch machine cycle of a small 8-bit processor core. The core uses a multiplexed bus: one byte of lines carries the low address byte in the first state and the data byte after it, and a dedicated byte of lines carries the high address byte. A start strobe begins a fixed four-state cycle, T1 to T4. In T1 the block drives the program counter onto the bus, pulses the address latch enable, and marks the cycle as a memory opcode fetch on the select and status pins. In T2 and T3 it asserts the read strobe. At the end of T3 it captures the opcode from the bus and presents it with a one-cycle valid pulse in T4.

The block holds a small general register file. When the fetched opcode is a one-byte register-to-register move, it does the copy itself as T4 closes. A side port lets the surrounding logic preload a register and read one back. The program counter steps by one at the end of every fetch. It can be loaded while the sequencer is idle. If start is held during T4, the next fetch follows with no idle cycle.

Top module: `fetch_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the block shows the idle state: `pc_out` = 0, `rd_n` = 1, `wr_n` = 1, `ale` = 0, `ad_oe` = 0, `op_valid` = 0, and `stat1` = `stat0` = 0.
- R2: Start sampled high while idle begins a cycle of exactly four states on the next clock. After T4 the sequencer returns to idle. If start is high in T4, it enters T1 directly.
- R3: `ale` and `ad_oe` are high in T1 and only in T1. In T1, `ad_out` equals the low byte of the program counter.
- R4: `addr_hi` equals the high byte of the program counter in all four states of a cycle.
- R5: `rd_n` is low in T2 and T3 and high in every other cycle. `wr_n` is high in every cycle.
- R6: During T1 to T4, `io_m` is 0 (memory) and `stat1` = `stat0` = 1 (opcode fetch). While idle, both status bits are 0.
- R7: The byte on `ad_in` at the clock edge that ends T3 is presented on `op_code`. `op_valid` is high for the single T4 cycle.
- R8: The program counter increases by one at the edge that ends T4, and wraps from FFFFh to 0000h.
- R9: An opcode of the form 01 ddd sss, where neither ddd nor sss equals 110, copies register sss into register ddd at the edge that ends T4. Register sss is left unchanged. Any other opcode leaves every register unchanged.
- R10: `pc_ld` loads `pc_ld_val` into the program counter only while idle. During a cycle it is ignored.
- R11: Start asserted in T1, T2 or T3 has no effect: the cycle ends in idle unless start is high in T4.
- R12: `rf_we` writes `rf_wdata` into register `rf_wsel`. `rf_rdata` shows register `rf_rsel` one clock after the select is applied. A move into the same register in the same cycle takes priority over the port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch cycle (sampled in idle or T4) |
| pc_ld | input | 1 | Load the program counter (idle only) |
| pc_ld_val | input | 16 | Value for a program counter load |
| ad_in | input | 8 | Multiplexed bus, input side |
| ad_out | output | 8 | Multiplexed bus, output side (low address byte in T1) |
| ad_oe | output | 1 | Output enable for the multiplexed bus |
| addr_hi | output | 8 | High address byte lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | IO (1) versus memory (0) select |
| stat1 | output | 1 | Cycle status bit 1 |
| stat0 | output | 1 | Cycle status bit 0 |
| op_code | output | 8 | Captured opcode |
| op_valid | output | 1 | One-cycle opcode valid pulse in T4 |
| pc_out | output | 16 | Current program counter |
| rf_we | input | 1 | Register file write enable |
| rf_wsel | input | 3 | Register file write index |
| rf_wdata | input | 8 | Register file write data |
| rf_rsel | input | 3 | Register file read index |
| rf_rdata | output | 8 | Register file read data (registered) |

## Verification
The hardest case to reach is a back-to-back fetch. Start must be raised in exactly the T4 cycle, so the next T1 follows with no idle state, and the second move must read a register that the first move wrote at that same edge. The bench drives start from its fetch task while the monitor process is still checking the first cycle's opcode, then runs the second fetch. It then reads both registers back through the side port. A second hard case is a load or start request that arrives mid-cycle. The bench raises both in T2, then shows that the counter only stepped by one and that no T1 followed.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } cyc_st_e;

  // move opcode layout: 01 ddd sss, index 110 selects memory and is not a register
  localparam logic [1:0] MOVE_TOP = 2'b01;
  localparam logic [2:0] MEM_IDX  = 3'b110;
endpackage

// File: rtl/fetch_fsm.sv
module fetch_fsm
  import fetch_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_ld_val,
  output cyc_st_e       st_q,
  output cyc_st_e       st_d,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_d
);
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: st_d = start ? ST_T1 : ST_IDLE;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3:   st_d = ST_T4;
      ST_T4:   st_d = start ? ST_T1 : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pc_d = pc_q;
    if (st_q == ST_IDLE && pc_ld)
      pc_d = pc_ld_val;
    else if (st_q == ST_T4)
      pc_d = pc_q + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/fetch_bus_drive.sv
module fetch_bus_drive
  import fetch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_st_e       st_d,
  input  logic [AW-1:0] pc_d,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m,
  output logic          stat1,
  output logic          stat0
);
  logic in_t1, active, reading;

  assign in_t1   = (st_d == ST_T1);
  assign active  = (st_d != ST_IDLE);
  assign reading = (st_d == ST_T2) || (st_d == ST_T3);

  // outputs are registered from the next-state view so they line up with the state
  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      addr_hi <= '0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      io_m    <= 1'b0;
      stat1   <= 1'b0;
      stat0   <= 1'b0;
    end else begin
      ad_out  <= in_t1 ? pc_d[DW-1:0] : '0;
      ad_oe   <= in_t1;
      addr_hi <= active ? pc_d[AW-1:DW] : '0;
      ale     <= in_t1;
      rd_n    <= ~reading;
      wr_n    <= 1'b1;
      io_m    <= 1'b0;
      stat1   <= active;
      stat0   <= active;
    end
  end
endmodule

// File: rtl/fetch_op_capture.sv
module fetch_op_capture
  import fetch_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_st_e       st_q,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] op_code,
  output logic          op_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_code  <= '0;
      op_valid <= 1'b0;
    end else begin
      op_valid <= (st_q == ST_T3);
      if (st_q == ST_T3)
        op_code <= ad_in;
    end
  end
endmodule

// File: rtl/fetch_reg_file.sv
module fetch_reg_file
  import fetch_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec,
  input  logic [DW-1:0] op_code,
  input  logic          we,
  input  logic [IW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] rsel,
  output logic [DW-1:0] rdata
);
  localparam int NREG = 1 << IW;

  logic [DW-1:0] regs [NREG];
  logic [IW-1:0] dst, src;
  logic          is_move;

  assign dst     = op_code[2*IW-1:IW];
  assign src     = op_code[IW-1:0];
  assign is_move = exec && (op_code[DW-1:DW-2] == MOVE_TOP) &&
                   (dst != MEM_IDX) && (src != MEM_IDX);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (is_move && dst == IW'(i))
        regs[i] <= regs[src];
      else if (we && wsel == IW'(i))
        regs[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= regs[rsel];
  end
endmodule

// File: rtl/fetch_cycle_seq.sv
module fetch_cycle_seq
  import fetch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_ld_val,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m,
  output logic          stat1,
  output logic          stat0,
  output logic [DW-1:0] op_code,
  output logic          op_valid,
  output logic [AW-1:0] pc_out,
  input  logic          rf_we,
  input  logic [IW-1:0] rf_wsel,
  input  logic [DW-1:0] rf_wdata,
  input  logic [IW-1:0] rf_rsel,
  output logic [DW-1:0] rf_rdata
);
  cyc_st_e       st_q, st_d;
  logic [AW-1:0] pc_d;

  fetch_fsm #(.AW(AW)) u_fsm (
    .clk, .rst, .start, .pc_ld, .pc_ld_val,
    .st_q, .st_d, .pc_q(pc_out), .pc_d
  );

  fetch_bus_drive #(.AW(AW), .DW(DW)) u_bus (
    .clk, .rst, .st_d, .pc_d,
    .ad_out, .ad_oe, .addr_hi, .ale, .rd_n, .wr_n, .io_m, .stat1, .stat0
  );

  fetch_op_capture #(.DW(DW)) u_cap (
    .clk, .rst, .st_q, .ad_in, .op_code, .op_valid
  );

  fetch_reg_file #(.DW(DW), .IW(IW)) u_rf (
    .clk, .rst, .exec(op_valid), .op_code,
    .we(rf_we), .wsel(rf_wsel), .wdata(rf_wdata),
    .rsel(rf_rsel), .rdata(rf_rdata)
  );
endmodule

// File: rtl/fetch_cycle_seq_chk.sv
module fetch_cycle_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ale,
  input logic          ad_oe,
  input logic          rd_n,
  input logic          wr_n,
  input logic          io_m,
  input logic          stat1,
  input logic          stat0,
  input logic          op_valid,
  input logic [AW-1:0] pc_out,
  input logic [AW-DW-1:0] addr_hi
);
  assert_t1_then_read_R3: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && !ad_oe && !rd_n));

  assert_oe_with_ale_R3: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> ale);

  assert_read_two_states_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |=> !rd_n);

  assert_read_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && $past(!rd_n)) |=> rd_n);

  assert_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_n);

  assert_fetch_status_R6: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || ale || op_valid) |-> (stat1 && stat0 && !io_m));

  assert_valid_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (rd_n && $past(!rd_n)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !op_valid);

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (pc_out == $past(pc_out) + AW'(1)));

  assert_hi_byte_R4: assert property (@(posedge clk) disable iff (rst)
    ale |-> (addr_hi == pc_out[AW-1:DW]));
endmodule

bind fetch_cycle_seq fetch_cycle_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk, .rst, .ale, .ad_oe, .rd_n, .wr_n, .io_m, .stat1, .stat0,
  .op_valid, .pc_out, .addr_hi
);

// File: tb/fetch_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        pc_ld = 1'b0;
  logic [15:0] pc_ld_val = '0;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out;
  logic        ad_oe, ale, rd_n, wr_n, io_m, stat1, stat0, op_valid;
  logic [7:0]  addr_hi, op_code, rf_rdata;
  logic [15:0] pc_out;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_wsel = '0, rf_rsel = '0;
  logic [7:0]  rf_wdata = '0;
  logic [7:0]  bus_op = '0;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_pc = '0;
  logic [23:0] exp_q[$];

  always #2 clk = ~clk;

  // memory model: returns the opcode while read is asserted
  assign ad_in = rd_n ? 8'h00 : bus_op;

  fetch_cycle_seq dut_i (
    .clk, .rst, .start, .pc_ld, .pc_ld_val, .ad_in,
    .ad_out, .ad_oe, .addr_hi, .ale, .rd_n, .wr_n, .io_m, .stat1, .stat0,
    .op_code, .op_valid, .pc_out,
    .rf_we, .rf_wsel, .rf_wdata, .rf_rsel, .rf_rdata
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected opcode and address at each valid pulse (R7)
  always @(negedge clk) begin
    if (!rst && op_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected op_valid", 32'(op_code), 32'h0);
      end else begin
        logic [23:0] it;
        it = exp_q.pop_front();
        chk(op_code == it[7:0], "R7 opcode", 32'(op_code), 32'(it[7:0]));
        chk(pc_out == it[23:8], "R7 pc during T4", 32'(pc_out), 32'(it[23:8]));
      end
    end
  end

  task automatic reg_write(input logic [2:0] sel, input logic [7:0] val);
    rf_we = 1'b1; rf_wsel = sel; rf_wdata = val;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic reg_check(input logic [2:0] sel, input logic [7:0] val, input string tag);
    rf_rsel = sel;
    @(negedge clk);
    chk(rf_rdata == val, tag, 32'(rf_rdata), 32'(val));
  endtask

  task automatic load_pc(input logic [15:0] v);
    pc_ld = 1'b1; pc_ld_val = v;
    @(negedge clk);
    pc_ld = 1'b0;
    exp_pc = v;
    chk(pc_out == v, "R10 pc load in idle", 32'(pc_out), 32'(v));
  endtask

  // entered at a negedge while idle or in T4; returns at the T4 negedge
  task automatic fetch(input logic [7:0] op, input bit poke);
    bus_op = op; start = 1'b1;
    exp_q.push_back({exp_pc, op});
    @(negedge clk); start = 1'b0;
    chk(ale && ad_oe, "R3 ale/oe in T1", {ale, ad_oe}, 2'b11);
    chk(ad_out == exp_pc[7:0], "R3 low address in T1", 32'(ad_out), 32'(exp_pc[7:0]));
    chk(addr_hi == exp_pc[15:8], "R4 high address in T1", 32'(addr_hi), 32'(exp_pc[15:8]));
    chk(rd_n && wr_n, "R5 strobes in T1", {rd_n, wr_n}, 2'b11);
    chk({io_m, stat1, stat0} == 3'b011, "R6 status in T1", {io_m, stat1, stat0}, 3'b011);
    @(negedge clk);
    chk(!rd_n && !ale && !ad_oe, "R5 T2 read", {rd_n, ale, ad_oe}, 3'b000);
    chk(addr_hi == exp_pc[15:8], "R4 high address in T2", 32'(addr_hi), 32'(exp_pc[15:8]));
    if (poke) begin
      pc_ld = 1'b1; pc_ld_val = 16'h1234; start = 1'b1;
    end
    @(negedge clk);
    pc_ld = 1'b0; start = 1'b0;
    chk(!rd_n && wr_n, "R5 T3 read", {rd_n, wr_n}, 2'b01);
    @(negedge clk);
    chk(rd_n && !ale, "R5 T4 read released", {rd_n, ale}, 2'b10);
    chk({io_m, stat1, stat0} == 3'b011, "R6 status in T4", {io_m, stat1, stat0}, 3'b011);
    exp_pc = exp_pc + 16'd1;
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    chk(!ale && rd_n && !stat1 && !stat0 && !op_valid, tag,
        {ale, rd_n, stat1, stat0, op_valid}, 5'b01000);
    chk(pc_out == exp_pc, "R8 pc after fetch", 32'(pc_out), 32'(exp_pc));
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pc_out == 16'h0 && rd_n && wr_n && !ale && !ad_oe && !op_valid && !stat1 && !stat0,
        "R1 reset state", {pc_out, rd_n, wr_n, ale, ad_oe, op_valid}, {16'h0, 6'b110000});
    rst = 1'b0;
    @(negedge clk);
    chk(pc_out == 16'h0 && !ale, "R1 idle after reset", 32'(pc_out), 0);

    // R12 side port
    reg_write(3'd0, 8'h11);
    reg_write(3'd1, 8'h5A);
    reg_write(3'd2, 8'h22);
    reg_write(3'd3, 8'h33);
    reg_check(3'd1, 8'h5A, "R12 port write/read");

    // R9 move 01 000 001: reg0 <= reg1
    load_pc(16'h2000);
    fetch(8'h41, 1'b0);
    idle_check("R2 idle after T4");
    reg_check(3'd0, 8'h5A, "R9 move destination");
    reg_check(3'd1, 8'h5A, "R9 move source unchanged");

    // R9 non-moves: memory destination, and non-01 top bits
    fetch(8'h70, 1'b0);
    idle_check("R2 idle after T4");
    reg_check(3'd6, 8'h00, "R9 memory index untouched");
    fetch(8'h3E, 1'b0);
    idle_check("R2 idle after T4");
    reg_check(3'd0, 8'h5A, "R9 non-move leaves reg0");
    reg_check(3'd7, 8'h00, "R9 non-move leaves reg7");

    // R2 back to back: 01 010 011 then 01 011 010
    fetch(8'h53, 1'b0);
    fetch(8'h5A, 1'b0);
    idle_check("R2 idle after chained fetch");
    reg_check(3'd2, 8'h33, "R9 chained first move");
    reg_check(3'd3, 8'h33, "R9 chained second move");

    // R10 and R11: load and start in T2 are ignored
    fetch(8'h00, 1'b1);
    idle_check("R11 start in T2 ignored");
    repeat (2) begin
      @(negedge clk);
      chk(!ale && rd_n, "R11 no extra cycle", {ale, rd_n}, 2'b01);
    end
    chk(pc_out == exp_pc, "R10 load during cycle ignored", 32'(pc_out), 32'(exp_pc));

    // R8 wrap
    load_pc(16'hFFFF);
    fetch(8'h00, 1'b0);
    idle_check("R2 idle after wrap fetch");
    chk(pc_out == 16'h0000, "R8 wrap to zero", 32'(pc_out), 0);

    // R12 priority: move into reg4 beats a port write at the same edge
    reg_write(3'd5, 8'hC3);
    bus_op = 8'h65; start = 1'b1;
    exp_q.push_back({exp_pc, 8'h65});
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk);
    rf_we = 1'b1; rf_wsel = 3'd4; rf_wdata = 8'h99;
    exp_pc = exp_pc + 16'd1;
    @(negedge clk);
    rf_we = 1'b0;
    reg_check(3'd4, 8'hC3, "R12 move wins over port write");

    chk(exp_q.size() == 0, "R7 all opcodes delivered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule